// File: doc/BRIEF.md
# Per-Pin Configuration Bank with Masked Broadcast Write

This block holds one configuration byte for each pin of an I/O port, plus a pin-select mask. Each configuration byte carries a drive/pull code, an input-sense code, a polarity-invert bit and a slew-limit bit. Software reaches the bank through a simple single-cycle register bus. A write to any pin's configuration address is normally copied into every configuration register whose mask bit is set. Several pins can therefore take the same setting in a single bus write.

When the mask is zero, a configuration write lands only in the addressed register, so ordinary single-pin writes keep working. Every register reads back at its own address. The stored fields are decoded into per-pin control lines for the pad and sense logic. These lines are: the normalised sense code, input enable, invert, slew limit, pull-up, pull-down, bus keeper, and the permission to drive high and to drive low.

Address map: addresses 0 to NPIN-1 select the configuration register of that pin, and address NPIN selects the mask. Byte layout: bits [2:0] hold the sense code, bits [5:3] the drive code, bit 6 invert and bit 7 slew limit.

Top module: `pin_cfg_bank`

## Requirements
- R1: After a synchronous active-low reset, every configuration register and the mask hold 0, and reading each of them returns 0.
- R2: A write to address NPIN stores the low NPIN bits of the write data in the mask, and reading address NPIN returns that mask.
- R3: While the mask is 0, a write to pin address k updates only register k, from the next clock edge on.
- R4: While the mask is nonzero, a write to any pin address stores the write data in every register whose mask bit is 1, from the next clock edge on.
- R5: While the mask is nonzero, a register whose mask bit is 0 keeps its value, including the register whose address was written.
- R6: Reading address k below NPIN returns register k. Addresses above NPIN read as 0, and writes to them change no register and not the mask.
- R7: Drive code bits [5:3] decode as follows. 0: push-pull. 1: push-pull with keeper. 2: push-pull with pull-down. 3: push-pull with pull-up. 4: wired-OR. 5: wired-AND. 6: wired-OR with pull-down. 7: wired-AND with pull-up. Wired-OR may drive high only, wired-AND may drive low only, and push-pull may drive both.
- R8: Sense code bits [2:0] decode as follows. 0: both edges. 1: rising. 2: falling. 3: low level. 4: disabled. Codes 5 to 7 are exported as 4, and input enable is 1 exactly when the exported code is not 4.
- R9: Bit 6 of each register drives that pin's invert output and bit 7 drives its slew-limit output (1 = limit).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| cfg_sense | output | 3*NPIN | Normalised sense code, 3 bits per pin |
| in_en | output | NPIN | Digital input enabled per pin |
| pin_inv | output | NPIN | Polarity invert per pin |
| pin_slew | output | NPIN | Slew limiting per pin |
| pull_up | output | NPIN | Internal pull-up on |
| pull_dn | output | NPIN | Internal pull-down on |
| keeper_en | output | NPIN | Bus keeper on |
| drv_hi_en | output | NPIN | Output stage may drive high |
| drv_lo_en | output | NPIN | Output stage may drive low |

## Verification
The hardest case to reach from the ports is a broadcast write whose addressed register is left out of the mask. It has to be told apart from a design that always writes the addressed register as well. The stimulus first loads distinct values into every register with the mask at zero. It then sets a sparse mask and writes to an unselected address. Reading all registers back afterwards shows that only the selected pins changed and that the addressed one kept its old byte. Reserved sense codes are reached by writing raw bytes with the sense field at 5 to 7.

// File: rtl/pin_cfg_pkg.sv
// Shared types for the pin configuration bank.
// Assumes an 8-bit register layout; field positions are fixed by pin_cfg_t.
package pin_cfg_pkg;
    localparam int REG_W = 8;

    typedef enum logic [2:0] {
        DRV_PP      = 3'd0,
        DRV_PP_KEEP = 3'd1,
        DRV_PP_PD   = 3'd2,
        DRV_PP_PU   = 3'd3,
        DRV_WOR     = 3'd4,
        DRV_WAND    = 3'd5,
        DRV_WOR_PD  = 3'd6,
        DRV_WAND_PU = 3'd7
    } drive_e;

    typedef enum logic [2:0] {
        SNS_BOTH = 3'd0,
        SNS_RISE = 3'd1,
        SNS_FALL = 3'd2,
        SNS_LOW  = 3'd3,
        SNS_OFF  = 3'd4
    } sense_e;

    typedef struct packed {
        logic       slew;
        logic       inv;
        logic [2:0] drv;
        logic [2:0] sense;
    } pin_cfg_t;
endpackage

// File: rtl/pin_cfg_wr_sel.sv
// Write-enable generation for the bank.
// Turns one bus write into per-register enables: the mask selects targets,
// or the addressed register alone when the mask is zero. Assumes NPIN < 2**AW.
module pin_cfg_wr_sel #(
    parameter int NPIN = 8,
    parameter int AW   = 4
) (
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NPIN-1:0] mask,
    output logic [NPIN-1:0] cfg_we,
    output logic            mask_we
);
    localparam logic [AW-1:0] MASK_ADDR = AW'(NPIN);

    logic pin_hit;

    // Classify the address: pin register range or the mask register.
    always_comb begin
        pin_hit = bus_we && (bus_addr < MASK_ADDR);
        mask_we = bus_we && (bus_addr == MASK_ADDR);
    end

    // Per-pin enable: mask broadcast, or single target when mask is empty.
    for (genvar i = 0; i < NPIN; i++) begin : g_sel
        always_comb begin
            if (mask == '0)
                cfg_we[i] = pin_hit && (bus_addr == AW'(i));
            else
                cfg_we[i] = pin_hit && mask[i];
        end
    end
endmodule

// File: rtl/pin_cfg_reg.sv
// One pin's configuration register.
// Loads wdata on we; holds otherwise. Synchronous active-low reset to zero.
module pin_cfg_reg
    import pin_cfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  pin_cfg_t wdata,
    output pin_cfg_t q
);
    // Storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (we)
            q <= wdata;
    end

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> q == $past(q));
endmodule

// File: rtl/pin_cfg_field_dec.sv
// Field decoder for one pin.
// Maps the stored drive and sense codes to pad/sense control lines.
// Purely combinational; reserved sense codes fold to "disabled".
module pin_cfg_field_dec
    import pin_cfg_pkg::*;
(
    input  pin_cfg_t   cfg,
    output logic [2:0] sense_n,
    output logic       in_en,
    output logic       inv,
    output logic       slew,
    output logic       pu,
    output logic       pd,
    output logic       keep,
    output logic       hi_en,
    output logic       lo_en
);
    // Drive/pull code decode.
    always_comb begin
        pu    = 1'b0;
        pd    = 1'b0;
        keep  = 1'b0;
        hi_en = 1'b1;
        lo_en = 1'b1;
        unique case (drive_e'(cfg.drv))
            DRV_PP:      ;
            DRV_PP_KEEP: keep = 1'b1;
            DRV_PP_PD:   pd = 1'b1;
            DRV_PP_PU:   pu = 1'b1;
            DRV_WOR:     lo_en = 1'b0;
            DRV_WAND:    hi_en = 1'b0;
            DRV_WOR_PD:  begin lo_en = 1'b0; pd = 1'b1; end
            DRV_WAND_PU: begin hi_en = 1'b0; pu = 1'b1; end
            default:     ;
        endcase
    end

    // Sense code normalisation and input buffer enable.
    always_comb begin
        sense_n = (cfg.sense > SNS_OFF) ? SNS_OFF : cfg.sense;
        in_en   = (sense_n != SNS_OFF);
        inv     = cfg.inv;
        slew    = cfg.slew;
    end
endmodule

// File: rtl/pin_cfg_bank.sv
// Per-pin configuration bank with masked broadcast write.
// Registers 0..NPIN-1 are pin configurations, register NPIN is the pin mask.
// Assumes NPIN <= 8 (mask fits the 8-bit bus) and NPIN < 2**AW.
module pin_cfg_bank
    import pin_cfg_pkg::*;
#(
    parameter int NPIN = 8,
    parameter int AW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic [3*NPIN-1:0] cfg_sense,
    output logic [NPIN-1:0]   in_en,
    output logic [NPIN-1:0]   pin_inv,
    output logic [NPIN-1:0]   pin_slew,
    output logic [NPIN-1:0]   pull_up,
    output logic [NPIN-1:0]   pull_dn,
    output logic [NPIN-1:0]   keeper_en,
    output logic [NPIN-1:0]   drv_hi_en,
    output logic [NPIN-1:0]   drv_lo_en
);
    localparam logic [AW-1:0] MASK_ADDR = AW'(NPIN);

    logic [NPIN-1:0] mask_q;
    logic [NPIN-1:0] cfg_we;
    logic            mask_we;
    pin_cfg_t        cfg_q [NPIN];

    pin_cfg_wr_sel #(.NPIN(NPIN), .AW(AW)) u_sel (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .mask     (mask_q),
        .cfg_we   (cfg_we),
        .mask_we  (mask_we)
    );

    // Pin mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= bus_wdata[NPIN-1:0];
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pin_cfg_reg u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (cfg_we[i]),
            .wdata (pin_cfg_t'(bus_wdata)),
            .q     (cfg_q[i])
        );

        pin_cfg_field_dec u_dec (
            .cfg     (cfg_q[i]),
            .sense_n (cfg_sense[3*i +: 3]),
            .in_en   (in_en[i]),
            .inv     (pin_inv[i]),
            .slew    (pin_slew[i]),
            .pu      (pull_up[i]),
            .pd      (pull_dn[i]),
            .keep    (keeper_en[i]),
            .hi_en   (drv_hi_en[i]),
            .lo_en   (drv_lo_en[i])
        );

        a_r1_reset_clear: assert property (@(posedge clk)
            !rst_n |=> cfg_q[i] == '0);
        a_r3_single_write: assert property (@(posedge clk) disable iff (!rst_n)
            bus_we && mask_q == '0 && bus_addr == AW'(i)
            |=> cfg_q[i] == pin_cfg_t'($past(bus_wdata)));
        a_r4_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
            bus_we && bus_addr < MASK_ADDR && mask_q[i]
            |=> cfg_q[i] == pin_cfg_t'($past(bus_wdata)));
        a_r5_unselected: assert property (@(posedge clk) disable iff (!rst_n)
            bus_we && mask_q != '0 && !mask_q[i] |=> $stable(cfg_q[i]));
        a_r7_can_drive: assert property (@(posedge clk) disable iff (!rst_n)
            drv_hi_en[i] || drv_lo_en[i]);
        a_r7_pull_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(pull_up[i] && pull_dn[i]));
        a_r8_sense_range: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_sense[3*i +: 3] <= 3'd4);
    end

    // Read-back multiplexer; unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NPIN; k++)
            if (bus_addr == AW'(k))
                bus_rdata = cfg_q[k];
        if (bus_addr == MASK_ADDR)
            bus_rdata = REG_W'(mask_q);
    end

    a_r1_mask_reset: assert property (@(posedge clk) !rst_n |=> mask_q == '0);
    a_r6_unmapped_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && bus_addr > MASK_ADDR |=> $stable(mask_q));
endmodule

// File: tb/sim_pin_cfg_bank.sv
module sim_pin_cfg_bank;
    localparam int NPIN = 8;
    localparam int AW   = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [7:0]        bus_wdata = '0;
    logic [7:0]        bus_rdata;
    logic [3*NPIN-1:0] cfg_sense;
    logic [NPIN-1:0]   in_en, pin_inv, pin_slew, pull_up, pull_dn;
    logic [NPIN-1:0]   keeper_en, drv_hi_en, drv_lo_en;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [NPIN];
    logic [7:0] model_mask;

    always #2 clk = ~clk;

    pin_cfg_bank #(.NPIN(NPIN), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_sense(cfg_sense),
        .in_en(in_en), .pin_inv(pin_inv), .pin_slew(pin_slew),
        .pull_up(pull_up), .pull_dn(pull_dn), .keeper_en(keeper_en),
        .drv_hi_en(drv_hi_en), .drv_lo_en(drv_lo_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Bus write; the model follows the requirements (R2, R3, R4, R5, R6).
    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a < NPIN) begin
            if (model_mask == 8'h00) model[a] = d;
            else for (int i = 0; i < NPIN; i++) if (model_mask[i]) model[i] = d;
        end else if (a == NPIN) begin
            model_mask = d;
        end
    endtask

    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic check_all_regs(input string req);
        for (int i = 0; i < NPIN; i++) rd_check(req, AW'(i), model[i]);
        rd_check(req, AW'(NPIN), model_mask);
    endtask

    task automatic t_reset;
        for (int i = 0; i < NPIN; i++) model[i] = 8'h00;
        model_mask = 8'h00;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all_regs("R1");
        check("R1 in_en", in_en, 8'hFF);
    endtask

    task automatic t_single;
        wr(4'd3, 8'hA5);
        check_all_regs("R3");
        for (int i = 0; i < NPIN; i++) wr(AW'(i), 8'(8'h10 + i));
        check_all_regs("R3 distinct");
    endtask

    task automatic t_mask_rw;
        wr(AW'(NPIN), 8'h5A);
        rd_check("R2", AW'(NPIN), 8'h5A);
        wr(AW'(NPIN), 8'h00);
        rd_check("R2 clear", AW'(NPIN), 8'h00);
    endtask

    task automatic t_broadcast;
        wr(AW'(NPIN), 8'b0011_0010);
        wr(4'd1, 8'h6C);
        check_all_regs("R4");
        check("R4 pin4", model[4], 8'h6C);
    endtask

    task automatic t_unselected_target;
        wr(AW'(NPIN), 8'b1000_0001);
        wr(4'd2, 8'hC3);
        check_all_regs("R5");
        check("R5 pin2 kept", model[2], 8'h12);
        wr(AW'(NPIN), 8'h00);
    endtask

    task automatic t_unmapped;
        wr(4'd12, 8'hFF);
        check_all_regs("R6 write ignored");
        rd_check("R6 unmapped read", 4'd12, 8'h00);
        rd_check("R6 unmapped read", 4'd15, 8'h00);
    endtask

    task automatic t_drive;
        logic [7:0] exp_hi, exp_lo, exp_pu, exp_pd, exp_kp;
        for (int i = 0; i < NPIN; i++) wr(AW'(i), 8'(i << 3));
        // code: 0 pp,1 keep,2 pd,3 pu,4 wor,5 wand,6 wor+pd,7 wand+pu
        exp_hi = 8'b0101_1111;
        exp_lo = 8'b1010_1111;
        exp_pu = 8'b1000_1000;
        exp_pd = 8'b0100_0100;
        exp_kp = 8'b0000_0010;
        @(negedge clk);
        check("R7 drv_hi_en", drv_hi_en, exp_hi);
        check("R7 drv_lo_en", drv_lo_en, exp_lo);
        check("R7 pull_up", pull_up, exp_pu);
        check("R7 pull_dn", pull_dn, exp_pd);
        check("R7 keeper_en", keeper_en, exp_kp);
    endtask

    task automatic t_sense;
        logic [3*NPIN-1:0] exp_s;
        for (int i = 0; i < NPIN; i++) wr(AW'(i), 8'(i));
        for (int i = 0; i < NPIN; i++) exp_s[3*i +: 3] = (i > 4) ? 3'd4 : 3'(i);
        @(negedge clk);
        check("R8 sense", cfg_sense, exp_s);
        check("R8 in_en", in_en, 8'b0000_1111);
    endtask

    task automatic t_inv_slew;
        wr(AW'(NPIN), 8'b0101_0101);
        wr(4'd1, 8'h40);
        wr(AW'(NPIN), 8'b1010_0000);
        wr(4'd0, 8'h80);
        @(negedge clk);
        check("R9 inv", pin_inv, 8'b0101_0101);
        check("R9 slew", pin_slew, 8'b1010_0000);
        check_all_regs("R9 readback");
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_single();
        t_mask_rw();
        t_broadcast();
        t_unselected_target();
        t_unmapped();
        t_drive();
        t_sense();
        t_inv_slew();
        t_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule